// File: doc/BRIEF.md
# E1 Transmit Frame Generator

This block sits in the transmit path of a 2.048 Mbit/s E1 line interface. It takes a serial payload stream one bit per strobe. Each frame holds 32 timeslots of 8 bits, sent MSB first, and each multiframe holds 16 frames. The block tracks bit, timeslot and frame position internally from reset and rewrites the bits that carry framing and overhead. With all options off, every bit passes through one register stage unchanged.

The framing overlays are enabled one by one from static configuration inputs. Together they build the frame alignment and non-alignment words in timeslot 0, a CRC-4 multiframe with a running checksum, and a channel-associated signalling multiframe in timeslot 16. An idle code can replace traffic timeslots. The remote alarm bit is raised either by a manual request or, when automatic mode is enabled, by a receive-side alarm. Signalling nibbles are fetched through a combinational lookup: the block presents a channel number on `sig_ch` and expects that channel's 4-bit value on `sig_nib` in the same cycle.

Bit numbering: bit 1 is the first bit of a timeslot on the line. Frames are numbered 0 to 15 within the multiframe. A sub-multiframe (SMF) is frames 0–7 or frames 8–15.

Top module: `e1_tx_framegen`

## Requirements
- R1: Each strobed input bit appears on `out_bit` with `out_valid` high in the cycle after the strobe. `out_valid` is low in every other cycle. A bit not touched by R2–R11 is passed through unchanged.
- R2: With `frm_en` high, bits 2–8 of timeslot 0 in even frames are 0,0,1,1,0,1,1.
- R3: With `frm_en` high, in timeslot 0 of odd frames, bit 2 is 1 and bits 4–8 are `nat_bits[4]` down to `nat_bits[0]`.
- R4: With `frm_en` high, bit 3 of timeslot 0 in odd frames equals `rai_manual | (rai_auto_en & rx_alarm)`.
- R5: With `frm_en` and `crc_en` high, bit 1 of timeslot 0 in odd frames 1, 3, 5, 7, 9 and 11 carries 0,0,1,0,1,1 in that order.
- R6: With `frm_en` and `crc_en` high and `crc_pass` low, bit 1 of timeslot 0 in SMF frames 0, 2, 4 and 6 carries C1..C4. These four bits are the remainder of x^4·M(x) divided by x^4+x+1, with C1 as the highest-order bit. M(x) is every output bit of the previous SMF, first bit highest order, with its four C positions counted as 0. The first SMF after reset carries 0000.
- R7: With `frm_en` and `crc_en` high, bit 1 of timeslot 0 is `~far_crc_err[0]` in frame 13 and `~far_crc_err[1]` in frame 15.
- R8: With `crc_pass` high, the C positions carry the input bit unchanged.
- R9: With `crc_en` low, bit 1 of timeslot 0 passes through in every frame.
- R10: With `sig_en` high, bits 1–4 of timeslot 16 in frame 0 are 0 and bits 5–8 pass through. In frame f from 1 to 15, bits 1–4 of timeslot 16 are the nibble of channel f and bits 5–8 are the nibble of channel f+15, MSB first. `sig_ch` names the channel being read during those bits and is 0 otherwise.
- R11: When `idle_req` and `pcc_en` are both high, `idle_code` (MSB first) replaces timeslots 1–31, except timeslot 16 while `sig_en` is high. With `pcc_en` low, `idle_req` has no effect.
- R12: With `frm_en` low, timeslot 0 passes through unchanged.
- R13: `frame_start` is high exactly with the output bit that is bit 1 of timeslot 0 of frame 0.
- R14: While reset is asserted, `out_valid`, `out_bit`, `frame_start` and `sig_ch` are 0, and the position returns to bit 1, timeslot 0, frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_strobe | input | 1 | Qualifies `bit_in` and advances the position |
| bit_in | input | 1 | Serial payload bit |
| frm_en | input | 1 | Enables timeslot 0 framing words |
| crc_en | input | 1 | Enables the CRC-4 multiframe |
| crc_pass | input | 1 | Passes C bits from the input |
| sig_en | input | 1 | Enables the timeslot 16 signalling multiframe |
| idle_req | input | 1 | Requests idle code substitution |
| pcc_en | input | 1 | Payload control enable that gates `idle_req` |
| idle_code | input | 8 | Idle byte |
| nat_bits | input | 5 | National bits 4–8 of the odd-frame word |
| rai_manual | input | 1 | Manual remote alarm |
| rai_auto_en | input | 1 | Lets `rx_alarm` raise the remote alarm |
| rx_alarm | input | 1 | Alarm from the receive side |
| far_crc_err | input | 2 | Far-end CRC errors for frames 13 and 15 |
| sig_nib | input | 4 | Signalling nibble of channel `sig_ch` |
| sig_ch | output | 5 | Channel whose nibble is being read |
| out_bit | output | 1 | Framed serial bit |
| out_valid | output | 1 | Qualifies `out_bit` |
| frame_start | output | 1 | Marks the first bit of a multiframe |

## Verification
The in-module assertions check a fixed set of rules on every cycle:
- the one-cycle relation between strobe and valid;
- `frame_start` is only high with valid output;
- the position wraps to zero after the last bit of a multiframe;
- the held CRC changes only at an SMF boundary;
- the alignment-word zero bit and the forced non-alignment bit;
- the idle byte in traffic timeslots.

The actual CRC values, the multiframe alignment and E-bit sequence, the channel mapping of the signalling nibbles, and the gating of one option by another can only be shown by the bench's scenarios. These run a reference model across whole multiframes under varied configurations and strobe gaps.

// File: rtl/e1fg_pkg.sv
package e1fg_pkg;
   localparam int E1_BITS  = 8;
   localparam int E1_SLOTS = 32;
   localparam int E1_FRAMES = 16;
   localparam int E1_SMF   = 8;
   localparam int E1_CRC_W = 4;
   localparam int E1_NAT_W = 5;

   localparam int BIDX_W = $clog2(E1_BITS);
   localparam int TS_W   = $clog2(E1_SLOTS);
   localparam int FR_W   = $clog2(E1_FRAMES);
   localparam int SMF_W  = $clog2(E1_SMF);

   localparam logic [6:0]          FAS_TAIL  = 7'b0011011;
   localparam logic [5:0]          MFAS_WORD = 6'b001011;
   localparam logic [E1_CRC_W-1:0] CRC4_POLY = 4'b0011;

   typedef struct packed {
      logic [FR_W-1:0]   frame;
      logic [TS_W-1:0]   ts;
      logic [BIDX_W-1:0] bidx;
   } e1_pos_t;
endpackage

// File: rtl/e1fg_pos_counter.sv
module e1fg_pos_counter
   import e1fg_pkg::*;
#(
   parameter int BITS   = E1_BITS,
   parameter int SLOTS  = E1_SLOTS,
   parameter int FRAMES = E1_FRAMES
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    adv,
   output e1_pos_t pos
);
   logic last_bit, last_ts, last_fr;

   assign last_bit = (pos.bidx  == BIDX_W'(BITS - 1));
   assign last_ts  = (pos.ts    == TS_W'(SLOTS - 1));
   assign last_fr  = (pos.frame == FR_W'(FRAMES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (adv) begin
         if (last_bit) begin
            pos.bidx <= '0;
            if (last_ts) begin
               pos.ts    <= '0;
               pos.frame <= last_fr ? '0 : pos.frame + 1'b1;
            end else begin
               pos.ts <= pos.ts + 1'b1;
            end
         end else begin
            pos.bidx <= pos.bidx + 1'b1;
         end
      end
   end

   // R14: the last bit of a multiframe is followed by position zero
   assert_pos_wrap_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && last_bit && last_ts && last_fr) |=> (pos == '0));
endmodule

// File: rtl/e1fg_crc4.sv
module e1fg_crc4
   import e1fg_pkg::*;
#(
   parameter int                 CRC_W = E1_CRC_W,
   parameter logic [CRC_W-1:0]   POLY  = CRC4_POLY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             din,
   input  logic             zero_pos,
   input  logic             smf_end,
   output logic [CRC_W-1:0] rem_hold
);
   logic [CRC_W-1:0] acc, nxt;
   logic             fb;

   assign fb = (din & ~zero_pos) ^ acc[CRC_W-1];

   for (genvar i = 0; i < CRC_W; i++) begin : g_lfsr
      if (i == 0) begin : g_lsb
         assign nxt[i] = fb & POLY[i];
      end else begin : g_upper
         assign nxt[i] = acc[i-1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         rem_hold <= '0;
      end else if (adv) begin
         if (smf_end) begin
            rem_hold <= nxt;
            acc      <= '0;
         end else begin
            acc <= nxt;
         end
      end
   end

   // R6: the CRC sent in an SMF is fixed for the whole SMF
   assert_crc_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(adv && smf_end) |=> $stable(rem_hold));
endmodule

// File: rtl/e1fg_overlay.sv
module e1fg_overlay
   import e1fg_pkg::*;
(
   input  e1_pos_t               pos,
   input  logic                  din,
   input  logic                  frm_en,
   input  logic                  crc_en,
   input  logic                  crc_pass,
   input  logic                  sig_en,
   input  logic                  idle_on,
   input  logic [E1_BITS-1:0]    idle_code,
   input  logic [E1_NAT_W-1:0]   nat_bits,
   input  logic                  rai,
   input  logic [1:0]            far_err,
   input  logic [E1_CRC_W-1:0]   crc_c,
   input  logic [3:0]            sig_nib,
   output logic                  dout,
   output logic                  c_pos,
   output logic [4:0]            sig_ch
);
   logic ts0, ts16;

   assign ts0   = (pos.ts == '0);
   assign ts16  = (pos.ts == TS_W'(16));
   assign c_pos = ts0 && !pos.frame[0] && (pos.bidx == '0);

   always_comb begin
      dout   = din;
      sig_ch = '0;
      if (frm_en && ts0) begin
         if (!pos.frame[0]) begin
            if (pos.bidx == '0) begin
               if (crc_en && !crc_pass) dout = crc_c[2'd3 - pos.frame[2:1]];
            end else begin
               dout = FAS_TAIL[3'd7 - pos.bidx];
            end
         end else begin
            case (pos.bidx)
               3'd0: begin
                  if (crc_en) begin
                     if (pos.frame[3:1] < 3'd6) dout = MFAS_WORD[3'd5 - pos.frame[3:1]];
                     else                       dout = ~far_err[pos.frame[1]];
                  end
               end
               3'd1:    dout = 1'b1;
               3'd2:    dout = rai;
               default: dout = nat_bits[3'd7 - pos.bidx];
            endcase
         end
      end else if (sig_en && ts16) begin
         if (pos.frame == '0) begin
            if (!pos.bidx[2]) dout = 1'b0;
         end else begin
            dout   = sig_nib[2'd3 - pos.bidx[1:0]];
            sig_ch = pos.bidx[2] ? (5'(pos.frame) + 5'd15) : 5'(pos.frame);
         end
      end else if (idle_on && !ts0) begin
         dout = idle_code[3'd7 - pos.bidx];
      end
   end
endmodule

// File: rtl/e1_tx_framegen.sv
module e1_tx_framegen
   import e1fg_pkg::*;
#(
   parameter int BITS_PER_SLOT   = E1_BITS,
   parameter int SLOTS_PER_FRAME = E1_SLOTS,
   parameter int FRAMES_PER_MF   = E1_FRAMES,
   parameter int FRAMES_PER_SMF  = E1_SMF,
   parameter int CRC_WIDTH       = E1_CRC_W,
   parameter int NAT_WIDTH       = E1_NAT_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bit_strobe,
   input  logic                     bit_in,
   input  logic                     frm_en,
   input  logic                     crc_en,
   input  logic                     crc_pass,
   input  logic                     sig_en,
   input  logic                     idle_req,
   input  logic                     pcc_en,
   input  logic [BITS_PER_SLOT-1:0] idle_code,
   input  logic [NAT_WIDTH-1:0]     nat_bits,
   input  logic                     rai_manual,
   input  logic                     rai_auto_en,
   input  logic                     rx_alarm,
   input  logic [1:0]               far_crc_err,
   input  logic [3:0]               sig_nib,
   output logic [4:0]               sig_ch,
   output logic                     out_bit,
   output logic                     out_valid,
   output logic                     frame_start
);
   localparam int LOC_SMF_W = $clog2(FRAMES_PER_SMF);

   if (BITS_PER_SLOT != E1_BITS || SLOTS_PER_FRAME != E1_SLOTS ||
       FRAMES_PER_MF != E1_FRAMES || FRAMES_PER_SMF != E1_SMF) begin : g_bad_geometry
      $error("e1_tx_framegen: frame geometry must match the E1 structure");
   end
   if (CRC_WIDTH != E1_CRC_W || NAT_WIDTH != E1_NAT_W) begin : g_bad_fields
      $error("e1_tx_framegen: CRC and national field widths are fixed by the frame");
   end

   e1_pos_t              pos;
   logic                 smf_end, ovl_bit, c_pos, rai, mf_first;
   logic [CRC_WIDTH-1:0] crc_c;

   assign rai      = rai_manual | (rai_auto_en & rx_alarm);
   assign smf_end  = (pos.bidx == BIDX_W'(BITS_PER_SLOT - 1)) &&
                     (pos.ts == TS_W'(SLOTS_PER_FRAME - 1)) &&
                     (pos.frame[LOC_SMF_W-1:0] == '1);
   assign mf_first = (pos == '0);

   e1fg_pos_counter #(
      .BITS(BITS_PER_SLOT), .SLOTS(SLOTS_PER_FRAME), .FRAMES(FRAMES_PER_MF)
   ) i_pos (
      .clk(clk), .rst_n(rst_n), .adv(bit_strobe), .pos(pos)
   );

   e1fg_overlay i_ovl (
      .pos(pos), .din(bit_in), .frm_en(frm_en), .crc_en(crc_en),
      .crc_pass(crc_pass), .sig_en(sig_en), .idle_on(idle_req & pcc_en),
      .idle_code(idle_code), .nat_bits(nat_bits), .rai(rai),
      .far_err(far_crc_err), .crc_c(crc_c), .sig_nib(sig_nib),
      .dout(ovl_bit), .c_pos(c_pos), .sig_ch(sig_ch)
   );

   e1fg_crc4 #(.CRC_W(CRC_WIDTH), .POLY(CRC4_POLY)) i_crc (
      .clk(clk), .rst_n(rst_n), .adv(bit_strobe), .din(ovl_bit),
      .zero_pos(c_pos), .smf_end(smf_end), .rem_hold(crc_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_bit     <= 1'b0;
         out_valid   <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         out_valid   <= bit_strobe;
         frame_start <= bit_strobe & mf_first;
         if (bit_strobe) out_bit <= ovl_bit;
      end
   end

   // R1: one output bit per strobe, one cycle later
   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |=> out_valid);
   assert_no_extra_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_strobe |=> !out_valid);
   // R13: the multiframe marker rides on a valid bit
   assert_fs_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> out_valid);
   // R2: bit 3 of the alignment word is zero
   assert_fas_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_strobe && frm_en && pos.ts == '0 && !pos.frame[0] && pos.bidx == 3'd2)
      |=> !out_bit);
   // R3: bit 2 of the non-alignment word is one
   assert_nfas_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_strobe && frm_en && pos.ts == '0 && pos.frame[0] && pos.bidx == 3'd1)
      |=> out_bit);
   // R11: idle byte in traffic slots
   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_strobe && idle_req && pcc_en && pos.ts != '0 && !(sig_en && pos.ts == TS_W'(16)))
      |=> (out_bit == $past(idle_code[3'd7 - pos.bidx])));
endmodule

// File: tb/test_e1_tx_framegen.sv
module test_e1_tx_framegen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_strobe = 1'b0, bit_in = 1'b0;
   logic       frm_en = 1'b0, crc_en = 1'b0, crc_pass = 1'b0, sig_en = 1'b0;
   logic       idle_req = 1'b0, pcc_en = 1'b0;
   logic [7:0] idle_code = 8'h00;
   logic [4:0] nat_bits = 5'h00;
   logic       rai_manual = 1'b0, rai_auto_en = 1'b0, rx_alarm = 1'b0;
   logic [1:0] far_crc_err = 2'b00;
   logic [3:0] sig_nib;
   logic [4:0] sig_ch;
   logic       out_bit, out_valid, frame_start;

   always #(CLK_PERIOD/2) clk = ~clk;

   e1_tx_framegen i_e1_tx_framegen (
      .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bit_in(bit_in),
      .frm_en(frm_en), .crc_en(crc_en), .crc_pass(crc_pass), .sig_en(sig_en),
      .idle_req(idle_req), .pcc_en(pcc_en), .idle_code(idle_code),
      .nat_bits(nat_bits), .rai_manual(rai_manual), .rai_auto_en(rai_auto_en),
      .rx_alarm(rx_alarm), .far_crc_err(far_crc_err), .sig_nib(sig_nib),
      .sig_ch(sig_ch), .out_bit(out_bit), .out_valid(out_valid),
      .frame_start(frame_start)
   );

   function automatic logic [3:0] sig_val(input logic [4:0] ch);
      return ch[3:0] ^ {ch[4], 3'b101};
   endfunction

   assign sig_nib = sig_val(sig_ch);

   typedef struct {
      logic  b;
      logic  fs;
      string tag;
   } exp_t;

   exp_t       q[$];
   exp_t       mon_e;
   int         n_checks = 0, n_fail = 0;
   int         m_fr = 0, m_ts = 0, m_b = 0;
   logic [4:0] m_div = '0;
   logic [3:0] m_hold = '0;
   logic [15:0] lfsr = 16'hACE1;
   bit         done = 1'b0;

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   task automatic model_reset();
      m_fr = 0; m_ts = 0; m_b = 0; m_div = '0; m_hold = '0;
      q.delete();
   endtask

   task automatic send_bit(input logic d);
      exp_t       e;
      logic       v, cb;
      logic [4:0] ch;
      logic [3:0] nib;
      string      t;
      v = d; t = "R1";
      if (m_ts == 0 && frm_en) begin
         if (m_fr % 2 == 0) begin
            if (m_b == 0) begin
               if (crc_en && !crc_pass) begin v = m_hold[3 - (m_fr % 8) / 2]; t = "R6"; end
               else if (crc_en) t = "R8";
               else t = "R9";
            end else begin
               v = (8'b0001_1011 >> (7 - m_b)) & 1; t = "R2";
            end
         end else begin
            case (m_b)
               0: if (crc_en) begin
                     if (m_fr <= 11) begin v = (6'b001011 >> (5 - (m_fr - 1) / 2)) & 1; t = "R5"; end
                     else begin v = !far_crc_err[(m_fr == 13) ? 0 : 1]; t = "R7"; end
                  end else t = "R9";
               1: begin v = 1'b1; t = "R3"; end
               2: begin v = rai_manual | (rai_auto_en & rx_alarm); t = "R4"; end
               default: begin v = nat_bits[7 - m_b]; t = "R3"; end
            endcase
         end
      end else if (m_ts == 16 && sig_en) begin
         t = "R10";
         if (m_fr == 0) v = (m_b < 4) ? 1'b0 : d;
         else begin
            ch  = (m_b < 4) ? 5'(m_fr) : 5'(m_fr + 15);
            nib = sig_val(ch);
            v   = nib[3 - (m_b % 4)];
         end
      end else if (m_ts != 0 && idle_req && pcc_en) begin
         v = idle_code[7 - m_b]; t = "R11";
      end else if (m_ts != 0 && idle_req) begin
         t = "R11";
      end else if (m_ts == 0) begin
         t = "R12";
      end
      e.b = v; e.fs = (m_fr == 0 && m_ts == 0 && m_b == 0); e.tag = t;
      q.push_back(e);
      // CRC reference by long division, C positions counted as zero
      cb = (m_ts == 0 && m_fr % 2 == 0 && m_b == 0) ? 1'b0 : v;
      m_div = {m_div[3:0], cb};
      if (m_div[4]) m_div = m_div ^ 5'b10011;
      if (m_b == 7 && m_ts == 31 && m_fr % 8 == 7) begin
         for (int k = 0; k < 4; k++) begin
            m_div = {m_div[3:0], 1'b0};
            if (m_div[4]) m_div = m_div ^ 5'b10011;
         end
         m_hold = m_div[3:0];
         m_div  = '0;
      end
      m_b++;
      if (m_b == 8) begin m_b = 0; m_ts++; end
      if (m_ts == 32) begin m_ts = 0; m_fr = (m_fr + 1) % 16; end
      bit_in = d; bit_strobe = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_bits(input int n, input int gap_mod);
      for (int i = 0; i < n; i++) begin
         send_bit(lfsr[0]);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (gap_mod != 0 && i % gap_mod == 0) begin
            bit_strobe = 1'b0;
            @(negedge clk);
         end
      end
      bit_strobe = 1'b0;
      repeat (3) @(negedge clk);
      n_checks++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R1: pending outputs actual=%0d expected=0", q.size());
      end
   endtask

   task automatic do_reset();
      bit_strobe = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || out_bit !== 1'b0 || frame_start !== 1'b0 || sig_ch !== 5'd0) begin
         n_fail++;
         $display("FAIL R14: reset outputs actual=%b%b%b/%0d expected=000/0",
                  out_valid, out_bit, frame_start, sig_ch);
      end
      model_reset();
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Monitor: pops the scoreboard whenever the design presents a bit
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R1: unexpected output actual valid=1 expected valid=0");
         end else begin
            mon_e = q.pop_front();
            n_checks++;
            if (out_bit !== mon_e.b) begin
               n_fail++;
               $display("FAIL %s: out_bit actual=%b expected=%b", mon_e.tag, out_bit, mon_e.b);
            end
            n_checks++;
            if (frame_start !== mon_e.fs) begin
               n_fail++;
               $display("FAIL R13: frame_start actual=%b expected=%b", frame_start, mon_e.fs);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run actual=hung expected=complete");
         report();
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1 R2 R3 R4 R9: basic framing only, continuous strobes
      frm_en = 1'b1; nat_bits = 5'b10110;
      do_reset();
      run_bits(4096, 0);

      // R5 R6 R7 R10 R4: CRC-4 and signalling multiframes, strobe gaps
      crc_en = 1'b1; sig_en = 1'b1; rai_manual = 1'b1; far_crc_err = 2'b01;
      nat_bits = 5'b01011;
      do_reset();
      run_bits(3 * 4096, 3);

      // R8 R11 R4: CRC pass-through, automatic alarm, idle skips TS16
      crc_pass = 1'b1; rai_manual = 1'b0; rai_auto_en = 1'b1; rx_alarm = 1'b1;
      idle_req = 1'b1; pcc_en = 1'b1; idle_code = 8'hC5; far_crc_err = 2'b10;
      do_reset();
      run_bits(4096, 5);

      // R11 R12: idle without payload enable has no effect, framing off
      frm_en = 1'b0; crc_en = 1'b0; crc_pass = 1'b0; sig_en = 1'b0; pcc_en = 1'b0;
      do_reset();
      run_bits(4096, 0);

      // R11 R6 R4: idle fills TS16 without signalling, auto alarm disabled
      frm_en = 1'b1; crc_en = 1'b1; pcc_en = 1'b1; idle_code = 8'h3A;
      rai_auto_en = 1'b0; far_crc_err = 2'b11;
      do_reset();
      run_bits(2 * 4096, 7);

      done = 1'b1;
      report();
      $finish;
   end
endmodule